// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block connects a host processor to a raw 8-bit NAND flash device through one 32-bit register. Every host write carries an operation code, a chip-enable bit and a data byte. The bridge turns the write into a command-latch cycle, an address-latch cycle or a data-write cycle on the flash pins. It can also arm a read mode instead. While read mode is armed, every host read of the register strobes one fresh byte out of the flash.

Every host read also reports whether the flash is busy. The host transaction is stalled until the strobe has finished. The host raises `host_req_i` and holds it together with its write flag and data until `host_ack_o` pulses for one clock. On a read, the result is on `host_rdata_o` in that same clock.

Register layout (write):

- bit 31 is the chip enable.
- bits 30:28 are the operation code.
- bits 23:16 are the byte.

Register layout (read):

- bits 23:16 are the byte.
- bit 15 is the busy flag.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nand_ce_n_o`, `nand_we_n_o` and `nand_re_n_o` are high, `nand_cle_o` and `nand_ale_o` are low, and the operation state is idle (code 111).
- R2: A write with code 000 holds `nand_cle_o` high and `nand_ale_o` low, and gives exactly one WE# pulse. The flash captures bits 23:16 of the write word on the rising edge of that pulse.
- R3: A write with code 001 holds `nand_ale_o` high and `nand_cle_o` low, and gives exactly one WE# pulse that latches bits 23:16.
- R4: A write with code 011 gives exactly one WE# pulse that latches bits 23:16 with both CLE and ALE low.
- R5: A write with code 111, 010, 100, 101 or 110 gives no WE# pulse and no RE# pulse, and leaves CLE and ALE low.
- R6: After any write, `nand_ce_n_o` equals the inverse of bit 31 of that write, and it holds that value through later reads.
- R7: After a write with code 010 and until the next write, each host read gives exactly one RE# pulse. The read returns the byte the flash drove during that pulse in bits 23:16. Successive reads return successive flash bytes.
- R8: Bit 15 of every read equals the inverse of `nand_rb_n_i`, once that input has been stable for at least two clocks. A read outside read mode gives no RE# pulse and returns 0 in bits 23:16.
- R9: Each WE# pulse and each RE# pulse is low for exactly STROBE_CYC clocks (default 2). WE# and RE# are never low together. `host_ack_o` is a single-clock pulse.
- R10: Bits 31:24 and 14:0 of every read word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host transaction request, held until acknowledged |
| host_we_i | input | 1 | 1 = register write, 0 = register read |
| host_wdata_i | input | 32 | Write word: enable, operation code, byte |
| host_rdata_o | output | 32 | Read word, valid while `host_ack_o` is high on a read |
| host_ack_o | output | 1 | One-clock completion pulse |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_io | inout | 8 | Flash data bus, driven only around WE# |
| nand_rb_n_i | input | 1 | Flash ready/busy, low = busy |

## Verification
The hardest case to reach is read mode that has lasted across several reads, each consuming a new flash byte. It matters most when it meets a write that silently disarms it, such as an unused code like 101. The stimulus mixes random codes from the whole 3-bit range with directed runs of back-to-back reads after arming. The flash model advances its byte pointer on every RE# rising edge, so any missing or extra pulse shows up as a wrong byte. Busy changes are applied a few clocks before each read, so that the flag has passed the synchronizer.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
   localparam logic [2:0] OP_CMD  = 3'b000;
   localparam logic [2:0] OP_ADDR = 3'b001;
   localparam logic [2:0] OP_READ = 3'b010;
   localparam logic [2:0] OP_DATA = 3'b011;
   localparam logic [2:0] OP_IDLE = 3'b111;

   localparam int unsigned BIT_CE     = 31;
   localparam int unsigned OP_LSB     = 28;
   localparam int unsigned BYTE_LSB   = 16;
   localparam int unsigned BIT_BUSY   = 15;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WLO, ST_WHI, ST_RLO, ST_RHI, ST_ACK
   } nrb_state_e;
endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= RESET_VAL;
         else if (i == 0) chain_q[i] <= d_i;
         else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nrb_timer.sv
module nrb_timer #(
   parameter int unsigned CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o,
   output logic first_o
);
   localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= RELOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done_o  = (cnt_q == '0);
   assign first_o = (cnt_q == RELOAD);
endmodule

// File: rtl/nrb_dq_port.sv
module nrb_dq_port #(
   parameter int unsigned DW = 8
) (
   input  logic          oe_i,
   input  logic [DW-1:0] dout_i,
   output logic [DW-1:0] din_o,
   inout  wire  [DW-1:0] pad_io
);
   assign pad_io = oe_i ? dout_i : {DW{1'bz}};
   assign din_o  = pad_io;
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
   import nrb_pkg::*;
#(
   parameter int unsigned STROBE_CYC  = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_req_i,
   input  logic        host_we_i,
   input  logic [31:0] host_wdata_i,
   output logic [31:0] host_rdata_o,
   output logic        host_ack_o,
   output logic        nand_cle_o,
   output logic        nand_ale_o,
   output logic        nand_ce_n_o,
   output logic        nand_we_n_o,
   output logic        nand_re_n_o,
   inout  wire  [7:0]  nand_dq_io,
   input  logic        nand_rb_n_i
);
   if (STROBE_CYC < 2) begin : g_bad_strobe
      $error("nand_reg_bridge: STROBE_CYC must be at least 2");
   end

   nrb_state_e st_q, st_d;
   logic [2:0] op_q;
   logic       ce_q;
   logic [7:0] wbyte_q;
   logic [7:0] rbyte_q;
   logic       rd_ack_q;
   logic       tmr_load, tmr_done, tmr_first;
   logic       dq_oe_q;
   logic [7:0] dq_in;
   logic       rb_n_sync;

   logic [2:0] op_in;
   logic       write_starts_cycle;
   logic       unused_wbits;

   assign op_in = host_wdata_i[OP_LSB +: 3];
   assign write_starts_cycle = (op_in == OP_CMD) || (op_in == OP_ADDR) ||
                               (op_in == OP_DATA);
   assign unused_wbits = ^{host_wdata_i[27:24], host_wdata_i[15:0]};

   nrb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (nand_rb_n_i),
      .q_o   (rb_n_sync)
   );

   nrb_timer #(.CYCLES(STROBE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tmr_load),
      .done_o  (tmr_done),
      .first_o (tmr_first)
   );

   nrb_dq_port #(.DW(8)) u_dq (
      .oe_i   (dq_oe_q),
      .dout_i (wbyte_q),
      .din_o  (dq_in),
      .pad_io (nand_dq_io)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      unique case (st_q)
         ST_IDLE: if (host_req_i) begin
            if (host_we_i) begin
               if (write_starts_cycle) begin
                  st_d = ST_WLO; tmr_load = 1'b1;
               end else st_d = ST_ACK;
            end else if (op_q == OP_READ) begin
               st_d = ST_RLO; tmr_load = 1'b1;
            end else st_d = ST_ACK;
         end
         ST_WLO: if (tmr_done) begin st_d = ST_WHI; tmr_load = 1'b1; end
         ST_WHI: if (tmr_done) st_d = ST_ACK;
         ST_RLO: if (tmr_done) begin st_d = ST_RHI; tmr_load = 1'b1; end
         ST_RHI: if (tmr_done) st_d = ST_ACK;
         ST_ACK: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         op_q     <= OP_IDLE;
         ce_q     <= 1'b0;
         wbyte_q  <= '0;
         rbyte_q  <= '0;
         rd_ack_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && host_req_i) begin
            if (host_we_i) begin
               op_q     <= op_in;
               ce_q     <= host_wdata_i[BIT_CE];
               wbyte_q  <= host_wdata_i[BYTE_LSB +: 8];
               rd_ack_q <= 1'b0;
            end else begin
               rd_ack_q <= 1'b1;
               if (op_q != OP_READ) rbyte_q <= '0;
            end
         end
         if (st_q == ST_RLO && tmr_done) rbyte_q <= dq_in;
      end
   end

   assign dq_oe_q = (st_q == ST_WLO) || (st_q == ST_WHI && tmr_first);

   assign nand_cle_o  = (op_q == OP_CMD);
   assign nand_ale_o  = (op_q == OP_ADDR);
   assign nand_ce_n_o = ~ce_q;
   assign nand_we_n_o = ~(st_q == ST_WLO);
   assign nand_re_n_o = ~(st_q == ST_RLO);
   assign host_ack_o  = (st_q == ST_ACK);

   always_comb begin
      host_rdata_o = '0;
      if (host_ack_o && rd_ack_q) begin
         host_rdata_o[BYTE_LSB +: 8] = rbyte_q;
         host_rdata_o[BIT_BUSY]      = ~rb_n_sync;
      end
   end
endmodule

// File: rtl/nrb_checker.sv
module nrb_checker (
   input logic clk,
   input logic rst_n,
   input logic cle,
   input logic ale,
   input logic ce_n,
   input logic we_n,
   input logic re_n,
   input logic ack,
   input logic dq_oe
);
   p_reset_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ce_n && we_n && re_n && !cle && !ale));

   p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));

   p_we_min_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |=> !we_n);

   p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   p_read_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> (!cle && !ale));

   p_bus_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe);

   p_drive_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> dq_oe);
endmodule

bind nand_reg_bridge nrb_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cle   (nand_cle_o),
   .ale   (nand_ale_o),
   .ce_n  (nand_ce_n_o),
   .we_n  (nand_we_n_o),
   .re_n  (nand_re_n_o),
   .ack   (host_ack_o),
   .dq_oe (dq_oe_q)
);

// File: tb/nand_reg_bridge_bench.sv
`timescale 1ns/1ps
module nand_reg_bridge_bench;
   localparam int T = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_ack;
   logic        cle, ale, ce_n, we_n, re_n;
   logic        rb_n = 1'b1;
   wire  [7:0]  dq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   nand_reg_bridge #(.STROBE_CYC(T)) u_nand_reg_bridge (
      .clk(clk), .rst_n(rst_n), .host_req_i(host_req), .host_we_i(host_we),
      .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .host_ack_o(host_ack),
      .nand_cle_o(cle), .nand_ale_o(ale), .nand_ce_n_o(ce_n),
      .nand_we_n_o(we_n), .nand_re_n_o(re_n), .nand_dq_io(dq), .nand_rb_n_i(rb_n)
   );

   // flash model
   int         we_count = 0, re_count = 0, flash_idx = 0;
   logic       lat_cle, lat_ale;
   logic [7:0] lat_byte;

   function automatic logic [7:0] flash_byte(int k);
      return 8'(k * 37 + 5);
   endfunction

   assign dq = (!re_n && !ce_n) ? flash_byte(flash_idx) : 8'hzz;

   always @(posedge we_n) if (rst_n) begin
      lat_cle = cle; lat_ale = ale; lat_byte = dq; we_count++;
   end
   always @(posedge re_n) if (rst_n) begin
      flash_idx++; re_count++;
   end

   int wlow = 0, rlow = 0, last_wlow = 0, last_rlow = 0;
   always @(posedge clk) begin
      if (!we_n) wlow++; else if (wlow != 0) begin last_wlow = wlow; wlow = 0; end
      if (!re_n) rlow++; else if (rlow != 0) begin last_rlow = rlow; rlow = 0; end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit we, input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_wdata = wd;
      do @(negedge clk); while (!host_ack);
      rd = host_rdata;
      host_req = 1'b0;
   endtask

   function automatic logic [31:0] mkw(bit ce, logic [2:0] op, logic [7:0] b);
      return {ce, op, 4'h0, b, 16'h0};
   endfunction

   bit model_read = 0;
   bit model_ce = 0;

   task automatic do_write(bit ce, logic [2:0] op, logic [7:0] b);
      logic [31:0] rd;
      int wc0, rc0;
      bit cyc;
      wc0 = we_count; rc0 = re_count;
      cyc = (op == 3'b000) || (op == 3'b001) || (op == 3'b011);
      xfer(1'b1, mkw(ce, op, b), rd);
      model_ce = ce; model_read = (op == 3'b010);
      chk(ce_n == !ce, "R6 ce_n after write", {31'h0, ce_n}, {31'h0, !ce});
      chk(re_count == rc0, "R5 no RE pulse on write", re_count, rc0);
      if (cyc) begin
         chk(we_count == wc0 + 1, "R2/R3/R4 one WE pulse", we_count, wc0 + 1);
         chk(lat_byte == b, "R2/R3/R4 latched byte", lat_byte, b);
         chk(lat_cle == (op == 3'b000) && lat_ale == (op == 3'b001),
             op == 3'b000 ? "R2 cle/ale" : (op == 3'b001 ? "R3 cle/ale" : "R4 cle/ale"),
             {lat_cle, lat_ale}, {op == 3'b000, op == 3'b001});
         chk(last_wlow == T, "R9 WE low width", last_wlow, T);
      end else begin
         chk(we_count == wc0, "R5 no WE pulse", we_count, wc0);
         chk(!cle && !ale, "R5 cle/ale low", {cle, ale}, 0);
      end
   endtask

   task automatic do_read(bit busy);
      logic [31:0] rd, exp;
      int rc0, idx0;
      rb_n = !busy;
      repeat (3) @(negedge clk);
      rc0 = re_count; idx0 = flash_idx;
      xfer(1'b0, 32'h0, rd);
      exp = '0;
      exp[15] = busy;
      if (model_read && model_ce) exp[23:16] = flash_byte(idx0);
      if (model_read) begin
         chk(re_count == rc0 + 1, "R7 one RE pulse per read", re_count, rc0 + 1);
         chk(last_rlow == T, "R9 RE low width", last_rlow, T);
      end else
         chk(re_count == rc0, "R8 no RE outside read mode", re_count, rc0);
      chk(rd[23:16] == exp[23:16], "R7/R8 read byte", rd, exp);
      chk(rd[15] == busy, "R8 busy bit", rd, exp);
      chk((rd & 32'hFF00_7FFF) == 0, "R10 unused bits zero", rd, exp);
      chk(ce_n == !model_ce, "R6 ce_n held through read", ce_n, !model_ce);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk(ce_n && we_n && re_n && !cle && !ale, "R1 reset pins",
          {ce_n, we_n, re_n, cle, ale}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ce_n && we_n && re_n && !cle && !ale, "R1 pins after release",
          {ce_n, we_n, re_n, cle, ale}, 5'b11100);
      do_read(1'b0);                       // R1: idle state, no read mode
      // directed
      do_write(1, 3'b000, 8'hFF);          // R2
      chk(cle && !ale, "R2 cle level held", {cle, ale}, 2'b10);
      do_write(1, 3'b001, 8'h00);          // R3
      chk(ale && !cle, "R3 ale level held", {cle, ale}, 2'b01);
      do_write(1, 3'b011, 8'hA5);          // R4
      do_write(1, 3'b111, 8'h3C);          // R5
      do_write(1, 3'b010, 8'h11);          // R7 arm
      do_read(1'b0); do_read(1'b1); do_read(1'b0); do_read(1'b0);
      do_write(1, 3'b101, 8'h22);          // R5 disarms
      do_read(1'b1);
      do_write(0, 3'b010, 8'h00);          // R6 ce released, read mode
      do_read(1'b0);
      // random
      for (int i = 0; i < 60; i++) begin
         int sel = $urandom_range(0, 3);
         if (sel == 0) do_read(1'($urandom_range(0, 1)));
         else do_write(1'($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)),
                       8'($urandom));
         if (sel == 1 && model_read)
            for (int j = 0; j < 3; j++) do_read(1'($urandom_range(0, 1)));
      end
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end
endmodule